// File: doc/BRIEF.md
# Flash command interface state machine

This block sits between an asynchronous 16-bit flash host bus and an internal write engine. The bus has three active-low strobes: chip enable, write enable and output enable. The block samples these strobes into its clock domain. It treats the end of each write strobe as a command cycle and decodes the command byte from the low eight bits of the data bus. Single-cycle commands change the current read mode or clear error flags. Two-cycle sequences launch program, erase, lock and protection-program operations. It launches each one with a one-cycle start pulse towards the write engine, along with an operation code, the word address and the data word.

While an operation is in flight, the block accepts only a suspend request. The full command set returns when the engine reports completion. A status byte reports readiness, suspension and error conditions. In status mode, reads return that byte as it stood when the read cycle began, that is, when the later of chip enable and output enable fell. Reads in array and query mode pass through data that the surrounding logic supplies for the current address. Identifier reads return two parameter words. The write engine is abstract: start, operation, address and data go out to it, and busy and done come back. Suspend and resume are single-cycle pulses.

Top module: `flash_cmd_if`

## Requirements
- R1: While reset is low, the data output enable stays low. After reset is released, the read mode is array and the status byte reads 80h. A reset during an operation abandons it.
- R2: The command byte is dq_in[7:0], taken when a write strobe ends. FFh selects array reads (array_rdata), 90h selects identifier reads, 70h selects status reads (status in dq_out[7:0], upper bits zero) and 98h selects query reads (query_rdata). In identifier mode, address 0 returns ID_MFR, address 1 returns ID_DEV and any other address returns 0.
- R3: 40h followed by a second write launches a program. The launch is one wsm_start pulse with wsm_op=1 that carries the second write's address and data. The mode then becomes status.
- R4: 20h followed by D0h launches an erase (wsm_op=2) at the address of the D0h write.
- R5: 20h followed by any byte other than D0h launches nothing. It sets status bits 5 (erase error) and 4 (program error), so status reads B0h, and the mode becomes status.
- R6: If a program, erase or protection program is attempted while vpp_ok is low, nothing is launched, status bit 3 is set (status 88h) and the mode becomes status.
- R7: From launch until wsm_done, status bit 7 (ready) reads 0. Every command other than B0h is ignored: there is no launch, no suspend and no change of read mode.
- R8: After wsm_done, bit 7 reads 1 and the full command set is accepted again.
- R9: B0h during a running program or erase pulses wsm_suspend once. It sets bit 2 for a program or bit 6 for an erase. Once wsm_busy is low, bit 7 reads 1, so status reads 84h or C0h.
- R10: While suspended, read-mode commands are accepted and setup commands (40h, 20h, 60h, C0h) are ignored. D0h pulses wsm_resume, clears the suspend bit and selects status mode.
- R11: 50h clears bits 5, 4 and 3 only and leaves the ready bit and the read mode unchanged.
- R12: A status read returns the status captured when the read cycle began. The value is held until the cycle ends, even if the status changes meanwhile.
- R13: 60h followed by any write launches a lock (wsm_op=3) with that write's data, whether or not vpp_ok is high. C0h followed by a write launches a protection program (wsm_op=4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| addr | input | AW | Word address |
| dq_in | input | DW | Write data; command byte in bits 7:0 |
| dq_out | output | DW | Read data |
| dq_oe | output | 1 | Output driver enable |
| array_rdata | input | DW | Array data for the current address |
| query_rdata | input | DW | Query table data for the current address |
| vpp_ok | input | 1 | Programming supply valid |
| wsm_start | output | 1 | One-cycle operation launch |
| wsm_op | output | 3 | Operation: 1 program, 2 erase, 3 lock, 4 protection program |
| wsm_addr | output | AW | Operation address |
| wsm_wdata | output | DW | Operation data |
| wsm_suspend | output | 1 | One-cycle suspend request |
| wsm_resume | output | 1 | One-cycle resume request |
| wsm_busy | input | 1 | Engine is working |
| wsm_done | input | 1 | One-cycle completion |

## Verification
The assertions check several properties on every clock. No operation is launched while one is in flight. Supply-dependent launches follow a valid supply. Start, suspend and resume never coincide. Ready is set right after completion. The output enable stays low in reset. Status output is stable within a read cycle. The bench scenarios cover what needs sequences of bus cycles. These include erase-confirm aborts for every second byte and the rejection of each byte while the engine runs. They also include suspend and resume of both operation kinds, the supply-error path, identifier and query reads over several addresses, and a status read held across completion.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;
  typedef enum logic [1:0] {RM_ARRAY, RM_ID, RM_STATUS, RM_QUERY} rd_mode_e;
  typedef enum logic [2:0] {SQ_IDLE, SQ_PGM, SQ_ERS, SQ_LCK, SQ_PRT} seq_e;

  localparam logic [2:0] OP_PROG  = 3'd1;
  localparam logic [2:0] OP_ERASE = 3'd2;
  localparam logic [2:0] OP_LOCK  = 3'd3;
  localparam logic [2:0] OP_PROT  = 3'd4;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_QUERY   = 8'h98;
  localparam logic [7:0] CMD_PGM     = 8'h40;
  localparam logic [7:0] CMD_ERS     = 8'h20;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_LOCK    = 8'h60;
  localparam logic [7:0] CMD_PROT    = 8'hC0;
endpackage

// File: rtl/flcmd_bus_sync.sv
module flcmd_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_end,
  output logic rd_act,
  output logic rd_start
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] ce_q, we_q, oe_q;
  logic wr_prev, rd_prev, wr_now;

  if (SYNC_STAGES < 2) begin : g_one
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ce_q <= '1;
        we_q <= '1;
        oe_q <= '1;
      end else begin
        ce_q <= ce_n;
        we_q <= we_n;
        oe_q <= oe_n;
      end
  end else begin : g_chain
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ce_q <= '1;
        we_q <= '1;
        oe_q <= '1;
      end else begin
        ce_q <= {ce_q[SYNC_STAGES-2:0], ce_n};
        we_q <= {we_q[SYNC_STAGES-2:0], we_n};
        oe_q <= {oe_q[SYNC_STAGES-2:0], oe_n};
      end
  end

  assign wr_now = ~ce_q[LAST] & ~we_q[LAST];
  assign rd_act = ~ce_q[LAST] & ~oe_q[LAST] & we_q[LAST];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_prev <= 1'b0;
      rd_prev <= 1'b0;
    end else begin
      wr_prev <= wr_now;
      rd_prev <= rd_act;
    end

  assign wr_end   = wr_prev & ~wr_now;
  assign rd_start = rd_act & ~rd_prev;
endmodule

// File: rtl/flcmd_decoder.sv
module flcmd_decoder
  import flcmd_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_end,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          vpp_ok,
  input  logic          wsm_busy,
  input  logic          wsm_done,
  output rd_mode_e      mode,
  output logic [7:0]    status,
  output logic          wsm_start,
  output logic [2:0]    wsm_op,
  output logic [AW-1:0] wsm_addr,
  output logic [DW-1:0] wsm_wdata,
  output logic          wsm_suspend,
  output logic          wsm_resume
);
  seq_e       seq;
  logic       op_run;
  logic [2:0] op_kind;
  logic       err_ers, err_prg, err_vpp, susp_ers, susp_prg;
  logic       suspended, running, ready;
  logic [7:0] code;

  assign code      = wdata[7:0];
  assign suspended = susp_ers | susp_prg;
  assign running   = op_run & ~suspended & ~wsm_done;
  assign ready     = ~op_run | (suspended & ~wsm_busy);
  assign status    = {ready, susp_ers, err_ers, err_prg, err_vpp, susp_prg, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq <= SQ_IDLE;
      mode <= RM_ARRAY;
      op_run <= 1'b0;
      op_kind <= '0;
      err_ers <= 1'b0;
      err_prg <= 1'b0;
      err_vpp <= 1'b0;
      susp_ers <= 1'b0;
      susp_prg <= 1'b0;
      wsm_start <= 1'b0;
      wsm_op <= '0;
      wsm_addr <= '0;
      wsm_wdata <= '0;
      wsm_suspend <= 1'b0;
      wsm_resume <= 1'b0;
    end else begin
      wsm_start <= 1'b0;
      wsm_suspend <= 1'b0;
      wsm_resume <= 1'b0;
      if (wsm_done) begin
        op_run <= 1'b0;
        susp_ers <= 1'b0;
        susp_prg <= 1'b0;
      end
      if (wr_end) begin
        if (running) begin
          if (code == CMD_SUSPEND && op_kind != OP_LOCK) begin
            wsm_suspend <= 1'b1;
            if (op_kind == OP_ERASE) susp_ers <= 1'b1;
            else susp_prg <= 1'b1;
          end
        end else if (seq != SQ_IDLE) begin
          seq <= SQ_IDLE;
          mode <= RM_STATUS;
          unique case (seq)
            SQ_PGM, SQ_PRT, SQ_ERS, SQ_LCK: begin
              if (seq == SQ_ERS && code != CMD_CONFIRM) begin
                err_ers <= 1'b1;
                err_prg <= 1'b1;
              end else if (seq != SQ_LCK && !vpp_ok) begin
                err_vpp <= 1'b1;
              end else begin
                wsm_start <= 1'b1;
                wsm_addr  <= addr;
                wsm_wdata <= wdata;
                op_run    <= 1'b1;
                case (seq)
                  SQ_PGM:  begin wsm_op <= OP_PROG;  op_kind <= OP_PROG;  end
                  SQ_ERS:  begin wsm_op <= OP_ERASE; op_kind <= OP_ERASE; end
                  SQ_LCK:  begin wsm_op <= OP_LOCK;  op_kind <= OP_LOCK;  end
                  default: begin wsm_op <= OP_PROT;  op_kind <= OP_PROT;  end
                endcase
              end
            end
            default: ;
          endcase
        end else begin
          case (code)
            CMD_ARRAY:  mode <= RM_ARRAY;
            CMD_IDENT:  mode <= RM_ID;
            CMD_STATUS: mode <= RM_STATUS;
            CMD_QUERY:  mode <= RM_QUERY;
            CMD_CLEAR: begin
              err_ers <= 1'b0;
              err_prg <= 1'b0;
              err_vpp <= 1'b0;
            end
            CMD_PGM:  if (!op_run) begin seq <= SQ_PGM; mode <= RM_STATUS; end
            CMD_ERS:  if (!op_run) begin seq <= SQ_ERS; mode <= RM_STATUS; end
            CMD_LOCK: if (!op_run) begin seq <= SQ_LCK; mode <= RM_STATUS; end
            CMD_PROT: if (!op_run) begin seq <= SQ_PRT; mode <= RM_STATUS; end
            CMD_CONFIRM:
              if (suspended && !wsm_done) begin
                wsm_resume <= 1'b1;
                susp_ers <= 1'b0;
                susp_prg <= 1'b0;
                mode <= RM_STATUS;
              end
            default: ;
          endcase
        end
      end
    end
  end

  AST_VPP_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wsm_start && wsm_op != OP_LOCK) |-> $past(vpp_ok)); // R6
  AST_NO_START_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    wsm_start |-> !$past(op_run)); // R7
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wsm_start, wsm_suspend, wsm_resume})); // R9
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wsm_done |=> status[7]); // R8
endmodule

// File: rtl/flcmd_rdpath.sv
module flcmd_rdpath
  import flcmd_pkg::*;
#(
  parameter int          AW     = 22,
  parameter int          DW     = 16,
  parameter logic [15:0] ID_MFR = 16'h00A7,
  parameter logic [15:0] ID_DEV = 16'h5E13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_act,
  input  logic          rd_start,
  input  rd_mode_e      mode,
  input  logic [7:0]    status,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] array_rdata,
  input  logic [DW-1:0] query_rdata,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  localparam logic [DW-1:0] MFR_W = DW'(ID_MFR);
  localparam logic [DW-1:0] DEV_W = DW'(ID_DEV);

  logic [7:0]    stat_hold;
  logic [7:0]    stat_now;
  logic [DW-1:0] sel;

  assign stat_now = rd_start ? status : stat_hold;

  always_comb begin
    unique case (mode)
      RM_ARRAY:  sel = array_rdata;
      RM_ID:     sel = (addr == AW'(0)) ? MFR_W : ((addr == AW'(1)) ? DEV_W : '0);
      RM_STATUS: sel = {{(DW-8){1'b0}}, stat_now};
      default:   sel = query_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat_hold <= '0;
      dq_out <= '0;
      dq_oe <= 1'b0;
    end else begin
      if (rd_start) stat_hold <= status;
      dq_out <= rd_act ? sel : '0;
      dq_oe <= rd_act;
    end

  AST_OE_LOW_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> !dq_oe); // R1
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe) && mode == RM_STATUS && $past(mode) == RM_STATUS)
      |-> $stable(dq_out)); // R12
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flcmd_pkg::*;
#(
  parameter int          AW          = 22,
  parameter int          DW          = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] ID_MFR      = 16'h00A7,
  parameter logic [15:0] ID_DEV      = 16'h5E13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] array_rdata,
  input  logic [DW-1:0] query_rdata,
  input  logic          vpp_ok,
  output logic          wsm_start,
  output logic [2:0]    wsm_op,
  output logic [AW-1:0] wsm_addr,
  output logic [DW-1:0] wsm_wdata,
  output logic          wsm_suspend,
  output logic          wsm_resume,
  input  logic          wsm_busy,
  input  logic          wsm_done
);
  logic       wr_end, rd_act, rd_start;
  rd_mode_e   mode;
  logic [7:0] status;

  flcmd_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wr_end(wr_end), .rd_act(rd_act), .rd_start(rd_start)
  );

  flcmd_decoder #(.AW(AW), .DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_end(wr_end), .addr(addr), .wdata(dq_in),
    .vpp_ok(vpp_ok), .wsm_busy(wsm_busy), .wsm_done(wsm_done),
    .mode(mode), .status(status), .wsm_start(wsm_start), .wsm_op(wsm_op),
    .wsm_addr(wsm_addr), .wsm_wdata(wsm_wdata),
    .wsm_suspend(wsm_suspend), .wsm_resume(wsm_resume)
  );

  flcmd_rdpath #(.AW(AW), .DW(DW), .ID_MFR(ID_MFR), .ID_DEV(ID_DEV)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .rd_start(rd_start),
    .mode(mode), .status(status), .addr(addr),
    .array_rdata(array_rdata), .query_rdata(query_rdata),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );
endmodule

// File: tb/flash_cmd_if_bench.sv
`timescale 1ns/1ps
module flash_cmd_if_bench;
  localparam int AW = 22;
  localparam logic [15:0] MFR = 16'h00A7;
  localparam logic [15:0] DEV = 16'h5E13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, array_rdata, query_rdata, wsm_wdata;
  logic dq_oe, vpp_ok = 1'b1;
  logic wsm_start, wsm_suspend, wsm_resume;
  logic [2:0] wsm_op;
  logic [AW-1:0] wsm_addr;
  logic busy_m, done_m, paused_m;
  int cnt_m;
  int lat = 10;
  int n_start = 0, n_susp = 0, n_res = 0;
  logic [2:0] last_op = '0;
  logic [AW-1:0] last_addr = '0;
  logic [15:0] last_data = '0;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign array_rdata = addr[15:0] ^ 16'h5A5A;
  assign query_rdata = ~addr[15:0];

  flash_cmd_if u_flash_cmd_if (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .array_rdata(array_rdata), .query_rdata(query_rdata), .vpp_ok(vpp_ok),
    .wsm_start(wsm_start), .wsm_op(wsm_op), .wsm_addr(wsm_addr),
    .wsm_wdata(wsm_wdata), .wsm_suspend(wsm_suspend), .wsm_resume(wsm_resume),
    .wsm_busy(busy_m), .wsm_done(done_m)
  );

  // write engine model with programmable latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_m <= 1'b0; done_m <= 1'b0; paused_m <= 1'b0; cnt_m <= 0;
    end else begin
      done_m <= 1'b0;
      if (wsm_start) begin
        busy_m <= 1'b1; cnt_m <= lat;
        n_start <= n_start + 1;
        last_op <= wsm_op; last_addr <= wsm_addr; last_data <= wsm_wdata;
      end else if (wsm_suspend) begin
        busy_m <= 1'b0; paused_m <= 1'b1; n_susp <= n_susp + 1;
      end else if (wsm_resume) begin
        busy_m <= 1'b1; paused_m <= 1'b0; n_res <= n_res + 1;
      end else if (busy_m) begin
        if (cnt_m == 0) begin busy_m <= 1'b0; done_m <= 1'b1; end
        else cnt_m <= cnt_m - 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d, output logic oe);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (6) @(negedge clk);
    d = dq_out; oe = dq_oe;
    oe_n = 1'b1; ce_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy_m) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  logic [15:0] d, d2, expv;
  logic oe;
  int ns, nsu;
  logic [7:0] codes [4] = '{8'hFF, 8'h90, 8'h70, 8'h98};

  initial begin
    // R1: reset state
    ce_n = 1'b0; oe_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R1 oe in reset", {31'd0, dq_oe}, 32'd0);
    ce_n = 1'b1; oe_n = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(22'd5, d, oe);
    chk("R1 array after reset", {16'd0, d}, {16'd0, 16'h0005 ^ 16'h5A5A});
    wr(0, 16'h0070);
    rd(0, d, oe);
    chk("R1 status after reset", {16'd0, d}, 32'h80);

    // R2: read mode sweep
    foreach (codes[i]) begin
      wr(0, {8'h00, codes[i]});
      for (int a = 0; a < 4; a++) begin
        rd(AW'(a), d, oe);
        case (codes[i])
          8'hFF: expv = 16'(a) ^ 16'h5A5A;
          8'h90: expv = (a == 0) ? MFR : ((a == 1) ? DEV : 16'h0000);
          8'h70: expv = 16'h0080;
          default: expv = ~16'(a);
        endcase
        chk("R2 mode data", {16'd0, d}, {16'd0, expv});
        chk("R2 oe", {31'd0, oe}, 32'd1);
      end
    end

    // R3: program
    lat = 30; ns = n_start;
    wr(0, 16'h0040);
    wr(22'h12345, 16'hBEEF);
    chk("R3 start count", n_start, ns + 1);
    chk("R3 op", {29'd0, last_op}, 32'd1);
    chk("R3 addr", {10'd0, last_addr}, 32'h12345);
    chk("R3 data", {16'd0, last_data}, 32'hBEEF);
    rd(0, d, oe);
    chk("R7 busy status", {16'd0, d}, 32'h00);
    wait_idle();
    rd(0, d, oe);
    chk("R8 ready status", {16'd0, d}, 32'h80);
    wr(0, 16'h00FF);
    rd(22'd3, d, oe);
    chk("R8 array accepted", {16'd0, d}, {16'd0, 16'h0003 ^ 16'h5A5A});

    // R4: erase
    ns = n_start;
    wr(22'h200, 16'h0020);
    wr(22'h2A0, 16'h00D0);
    chk("R4 start count", n_start, ns + 1);
    chk("R4 op", {29'd0, last_op}, 32'd2);
    chk("R4 addr", {10'd0, last_addr}, 32'h2A0);
    wait_idle();
    rd(0, d, oe);
    chk("R4 done status", {16'd0, d}, 32'h80);

    // R5: erase confirm abort, every other second byte
    ns = n_start;
    for (int c = 0; c < 256; c++) begin
      if (c == 8'hD0) continue;
      wr(0, 16'h0050);
      wr(0, 16'h0020);
      wr(0, 16'(c));
      rd(0, d, oe);
      chk("R5 abort status", {16'd0, d}, 32'hB0);
    end
    chk("R5 no start", n_start, ns);

    // R6 and R11: supply error, clear
    vpp_ok = 1'b0; ns = n_start;
    wr(0, 16'h0050);
    wr(0, 16'h0040);
    wr(22'h10, 16'h1234);
    rd(0, d, oe);
    chk("R6 program vpp err", {16'd0, d}, 32'h88);
    wr(0, 16'h0050);
    rd(0, d, oe);
    chk("R11 clear status", {16'd0, d}, 32'h80);
    wr(0, 16'h0020);
    wr(0, 16'h00D0);
    rd(0, d, oe);
    chk("R6 erase vpp err", {16'd0, d}, 32'h88);
    wr(0, 16'h0050);
    wr(0, 16'h00C0);
    wr(22'h3, 16'h7777);
    rd(0, d, oe);
    chk("R6 prot vpp err", {16'd0, d}, 32'h88);
    chk("R6 no start", n_start, ns);
    wr(0, 16'h0050);

    // R13: lock without supply, protection program with supply
    lat = 5;
    wr(22'h40, 16'h0060);
    wr(22'h41, 16'h0001);
    chk("R13 lock start", n_start, ns + 1);
    chk("R13 lock op", {29'd0, last_op}, 32'd3);
    chk("R13 lock data", {16'd0, last_data}, 32'h0001);
    wait_idle();
    vpp_ok = 1'b1;
    wr(0, 16'h00C0);
    wr(22'h8, 16'hA55A);
    chk("R13 prot op", {29'd0, last_op}, 32'd4);
    chk("R13 prot data", {16'd0, last_data}, 32'hA55A);
    wait_idle();

    // R7: every byte but suspend ignored while running
    lat = 8000; ns = n_start; nsu = n_susp;
    wr(0, 16'h0040);
    wr(22'h99, 16'h0F0F);
    chk("R7 long start", n_start, ns + 1);
    for (int c = 0; c < 256; c++) begin
      if (c == 8'hB0) continue;
      wr(22'h1, 16'(c));
      rd(22'h1, d, oe);
      chk("R7 ignored byte", {16'd0, d}, 32'h00);
    end
    chk("R7 no new start", n_start, ns + 1);
    chk("R7 no suspend", n_susp, nsu);

    // R9 and R10: program suspend, reads, rejected setup, resume
    wr(0, 16'h00B0);
    chk("R9 suspend pulse", n_susp, nsu + 1);
    rd(0, d, oe);
    chk("R9 program suspended", {16'd0, d}, 32'h84);
    wr(0, 16'h00FF);
    rd(22'h6, d, oe);
    chk("R10 array while suspended", {16'd0, d}, {16'd0, 16'h0006 ^ 16'h5A5A});
    wr(0, 16'h0040);
    wr(22'h7, 16'h1111);
    chk("R10 setup rejected", n_start, ns + 1);
    rd(22'h7, d, oe);
    chk("R10 mode kept", {16'd0, d}, {16'd0, 16'h0007 ^ 16'h5A5A});
    wr(0, 16'h00D0);
    chk("R10 resume pulse", n_res, 1);
    rd(0, d, oe);
    chk("R10 resumed status", {16'd0, d}, 32'h00);
    wait_idle();
    rd(0, d, oe);
    chk("R8 done after resume", {16'd0, d}, 32'h80);

    // R9: erase suspend
    lat = 300;
    wr(22'h500, 16'h0020);
    wr(22'h500, 16'h00D0);
    wr(0, 16'h00B0);
    rd(0, d, oe);
    chk("R9 erase suspended", {16'd0, d}, 32'hC0);
    wr(0, 16'h00D0);
    chk("R10 erase resume", n_res, 2);
    wait_idle();
    rd(0, d, oe);
    chk("R9 erase finished", {16'd0, d}, 32'h80);

    // R12: status held across completion within one read cycle
    lat = 40;
    wr(0, 16'h0040);
    wr(22'h20, 16'h2222);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    repeat (6) @(negedge clk);
    d = dq_out;
    chk("R12 first sample", {16'd0, d}, 32'h00);
    while (busy_m) @(negedge clk);
    repeat (6) @(negedge clk);
    d2 = dq_out;
    chk("R12 held sample", {16'd0, d2}, 32'h00);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(0, d, oe);
    chk("R12 next cycle", {16'd0, d}, 32'h80);

    // R1: reset during operation
    lat = 500;
    wr(0, 16'h0040);
    wr(22'h30, 16'h3333);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(22'h9, d, oe);
    chk("R1 array after mid reset", {16'd0, d}, {16'd0, 16'h0009 ^ 16'h5A5A});
    wr(0, 16'h0070);
    rd(0, d, oe);
    chk("R1 ready after mid reset", {16'd0, d}, 32'h80);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule